// File: doc/BRIEF.md
# Edge-Counting Frequency Lock Loop

This block steers the period word of a programmable-period oscillator so that the oscillator's cycle rate settles against an external reference clock. The oscillator sits outside the block. It restarts its cycle at each origin event, so its frequency follows whatever period word it is given. The block watches the origin signal and counts its rising edges over each reference-clock period. At the end of every reference period it makes a single binary decision. If two or more edges arrived, the oscillator is too fast and the period word grows by one. If one edge or none arrived, the oscillator is too slow and the period word shrinks by one.

The reference clock is brought into the system clock domain through a two-flop synchroniser. This keeps every decision clean even when reference and origin edges nearly coincide. The up/down period counter saturates at configured limits. Once the loop has settled, the word hunts between neighbouring values. A lock detector tracks a running centre value and raises a flag after the word has stayed within one count of that centre for a configured number of consecutive reference periods.

Top module: `freq_lock_loop`

## Requirements
- R1: The first synchronised reference rising edge after reset only opens a counting window; the period word does not change on it.
- R2: A window that closed with two or more origin rising edges raises the period word by exactly one.
- R3: A window that closed with zero or one origin rising edge lowers the period word by exactly one.
- R4: The period word changes only once per closed window; three or more edges act exactly like two.
- R5: The period word saturates at MIN_PERIOD (default 8) and MAX_PERIOD (default 4000) and never wraps.
- R6: During reset the period word holds init_period clamped into [MIN_PERIOD, MAX_PERIOD], the lock centre takes that same value and locked is 0.
- R7: An origin level held high for several cycles counts as one edge.
- R8: After each update, a word within ±1 of the centre extends a run; locked is 1 once the run reaches LOCK_LEN (default 16) updates.
- R9: A word outside ±1 of the centre moves the centre to that word, clears the run and drops locked on the next edge.
- R10: The period word takes its new value on the third clock edge after the edge that first samples the reference input high; the lock state follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_in | input | 1 | Reference clock, asynchronous to clk |
| origin_in | input | 1 | Oscillator cycle-origin signal, clk domain |
| init_period | input | PW | Period word loaded during reset |
| period_word | output | PW | Current oscillator period word |
| locked | output | 1 | Lock indicator |

## Verification
The hardest state to reach from the ports is the lock itself. It needs a long, unbroken run of updates that stay within one count of a centre, and then a clean break out of that band. The bench gets there with a directed stretch of alternating one-edge and two-edge windows, which makes the word hunt between two neighbours. It follows this with consecutive empty windows that drag the word away. Saturation is reached by reset values placed just inside each limit. Random edge counts cover the rest.

// File: rtl/fll_pkg.sv
package fll_pkg;

  // Clamp a value into the legal period range.
  function automatic int unsigned clamp_period(input int unsigned val,
                                               input int unsigned lo,
                                               input int unsigned hi);
    if (val < lo) return lo;
    if (val > hi) return hi;
    return val;
  endfunction

  // One saturating step of the loop filter.
  function automatic int unsigned step_period(input int unsigned cur,
                                              input bit          go_up,
                                              input int unsigned lo,
                                              input int unsigned hi);
    if (go_up) return (cur >= hi) ? hi : cur + 1;
    return (cur <= lo) ? lo : cur - 1;
  endfunction

  // True when word lies within one count of centre.
  function automatic bit near_centre(input int unsigned word,
                                     input int unsigned centre);
    return (word + 1 >= centre) && (word <= centre + 1);
  endfunction

endpackage

// File: rtl/fll_ref_sync.sv
module fll_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_tick
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ref_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign ref_tick = sync_q[STAGES-1] & ~last_q;

  // R10: a window boundary lasts one cycle
  a_r10_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> !ref_tick);
endmodule

// File: rtl/fll_edge_window.sv
module fll_edge_window (
  input  logic clk,
  input  logic rst_n,
  input  logic origin_in,
  input  logic ref_tick,
  output logic origin_rise,
  output logic pd_valid,
  output logic pd_up
);
  logic       origin_q;
  logic       armed_q;
  logic [1:0] edge_cnt;

  assign origin_rise = origin_in & ~origin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      origin_q <= 1'b0;
      armed_q  <= 1'b0;
      edge_cnt <= 2'd0;
      pd_valid <= 1'b0;
      pd_up    <= 1'b0;
    end else begin
      origin_q <= origin_in;
      pd_valid <= 1'b0;
      if (ref_tick) begin
        armed_q  <= 1'b1;
        if (armed_q) begin
          pd_valid <= 1'b1;
          pd_up    <= (edge_cnt == 2'd2);
        end
        edge_cnt <= origin_rise ? 2'd1 : 2'd0;
      end else if (origin_rise && edge_cnt != 2'd2) begin
        edge_cnt <= edge_cnt + 2'd1;
      end
    end
  end

  // R1/R4: decisions only follow a window boundary
  a_r4_decision_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pd_valid |-> $past(ref_tick));
  // R7: a held level produces one rise
  a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    origin_rise |=> !origin_rise);
  // R4: at most one decision per boundary
  a_r4_one_decision: assert property (@(posedge clk) disable iff (!rst_n)
    pd_valid |=> !pd_valid);
endmodule

// File: rtl/fll_period_ctr.sv
module fll_period_ctr #(
  parameter int PW         = 12,
  parameter int MIN_PERIOD = 8,
  parameter int MAX_PERIOD = 4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] init_period,
  input  logic          pd_valid,
  input  logic          pd_up,
  output logic [PW-1:0] period_word,
  output logic          step_done
);
  import fll_pkg::*;

  localparam logic [PW-1:0] LO = PW'(MIN_PERIOD);
  localparam logic [PW-1:0] HI = PW'(MAX_PERIOD);

  logic [PW-1:0] next_word;

  always_comb begin
    next_word = PW'(step_period(32'(period_word), pd_up,
                                MIN_PERIOD, MAX_PERIOD));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_word <= PW'(clamp_period(32'(init_period), MIN_PERIOD, MAX_PERIOD));
      step_done   <= 1'b0;
    end else begin
      step_done <= pd_valid;
      if (pd_valid) period_word <= next_word;
    end
  end

  // R5: word stays within the legal range
  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (period_word >= LO) && (period_word <= HI));
  // R4: no change without a decision
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_valid |=> $stable(period_word));
  // R2: upward decisions step by one or sit at the ceiling
  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_valid && pd_up) |=>
      (period_word == $past(period_word) + 1'b1) || (period_word == HI));
  // R3: downward decisions step by one or sit at the floor
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_valid && !pd_up) |=>
      (period_word == $past(period_word) - 1'b1) || (period_word == LO));
endmodule

// File: rtl/fll_lock_detect.sv
module fll_lock_detect #(
  parameter int PW       = 12,
  parameter int LOCK_LEN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] centre_init,
  input  logic          step_done,
  input  logic [PW-1:0] period_word,
  output logic          in_band,
  output logic          locked
);
  import fll_pkg::*;

  localparam int CW = $clog2(LOCK_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(LOCK_LEN);

  logic [PW-1:0] centre_q;
  logic [CW-1:0] run_q;

  assign in_band = near_centre(32'(period_word), 32'(centre_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      centre_q <= centre_init;
      run_q    <= '0;
      locked   <= 1'b0;
    end else if (step_done) begin
      if (in_band) begin
        if (run_q != RUN_MAX) begin
          run_q <= run_q + 1'b1;
          locked <= (run_q + 1'b1 == RUN_MAX);
        end
      end else begin
        centre_q <= period_word;
        run_q    <= '0;
        locked   <= 1'b0;
      end
    end
  end

  // R8: lock only rises right after an update
  a_r8_rise_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(step_done && in_band));
  // R9: lock only falls after an out-of-band update
  a_r9_fall_on_leave: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(step_done && !in_band));
endmodule

// File: rtl/freq_lock_loop.sv
module freq_lock_loop #(
  parameter int PW         = 12,
  parameter int MIN_PERIOD = 8,
  parameter int MAX_PERIOD = 4000,
  parameter int LOCK_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_clk_in,
  input  logic          origin_in,
  input  logic [PW-1:0] init_period,
  output logic [PW-1:0] period_word,
  output logic          locked
);
  import fll_pkg::*;

  logic          ref_tick;
  logic          origin_rise;
  logic          pd_valid;
  logic          pd_up;
  logic          step_done;
  logic          in_band;
  logic [PW-1:0] centre_init;

  assign centre_init = PW'(clamp_period(32'(init_period), MIN_PERIOD, MAX_PERIOD));

  fll_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_clk_in), .ref_tick(ref_tick));

  fll_edge_window u_window (
    .clk(clk), .rst_n(rst_n), .origin_in(origin_in), .ref_tick(ref_tick),
    .origin_rise(origin_rise), .pd_valid(pd_valid), .pd_up(pd_up));

  fll_period_ctr #(.PW(PW), .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD)) u_ctr (
    .clk(clk), .rst_n(rst_n), .init_period(init_period),
    .pd_valid(pd_valid), .pd_up(pd_up),
    .period_word(period_word), .step_done(step_done));

  fll_lock_detect #(.PW(PW), .LOCK_LEN(LOCK_LEN)) u_lock (
    .clk(clk), .rst_n(rst_n), .centre_init(centre_init),
    .step_done(step_done), .period_word(period_word),
    .in_band(in_band), .locked(locked));

  // R10: a closed window updates the word two edges after its boundary
  a_r10_update_latency: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> $past(ref_tick, 2));
endmodule

// File: tb/freq_lock_loop_tb.sv
module freq_lock_loop_tb;
  localparam int PW = 12;
  localparam int LO = 8;
  localparam int HI = 4000;
  localparam int RUN = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_clk_in = 1'b0;
  logic          origin_in = 1'b0;
  logic [PW-1:0] init_period = '0;
  logic [PW-1:0] period_word;
  logic          locked;

  int checks = 0;
  int fails = 0;
  int exp_word, exp_centre, exp_run;
  bit exp_lock;
  bit have_prev;
  int prev_n;

  always #5ns clk = ~clk;

  freq_lock_loop u_dut (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .origin_in(origin_in),
    .init_period(init_period), .period_word(period_word), .locked(locked));

  function automatic int bounded(input int v);
    int r = v;
    if (r < LO) r = LO;
    else if (r > HI) r = HI;
    return r;
  endfunction

  task automatic model_update(input int n);
    int d;
    exp_word = bounded(exp_word + ((n >= 2) ? 1 : -1));
    d = exp_word - exp_centre;
    if (d >= -1 && d <= 1) begin
      if (exp_run < RUN) exp_run++;
    end else begin
      exp_centre = exp_word;
      exp_run = 0;
    end
    exp_lock = (exp_run >= RUN);
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check_int(tag, int'(period_word), exp_word);
    check_int(tag, int'(locked), int'(exp_lock));
  endtask

  task automatic do_reset(input int init);
    @(negedge clk);
    rst_n = 1'b0; ref_clk_in = 1'b0; origin_in = 1'b0;
    init_period = PW'(init);
    repeat (3) @(negedge clk);
    exp_word = bounded(init); exp_centre = exp_word; exp_run = 0; exp_lock = 0;
    have_prev = 0;
    check_state("R6");
    rst_n = 1'b1;
  endtask

  // One reference period of 40 cycles carrying n short origin pulses,
  // or a single 6-cycle pulse when held is set.
  task automatic run_window(input string tag, input int n, input bit held,
                            input bit latency_probe);
    int old_word = exp_word;
    bit opened = have_prev;
    if (have_prev) model_update(prev_n);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      ref_clk_in = (c < 20);
      if (held) origin_in = (c >= 8 && c < 14);
      else      origin_in = (c >= 8 && c < 8 + 4*n && ((c - 8) % 4) == 0);
      if (latency_probe && opened && c == 3) check_int("R10", int'(period_word), old_word);
      if (latency_probe && opened && c == 4) check_int("R10", int'(period_word), exp_word);
      if (c == 12) check_state(opened ? tag : "R1");
    end
    prev_n = held ? 1 : n;
    have_prev = 1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset(100);
    run_window("R1", 3, 0, 0);
    run_window("R2", 2, 0, 1);
    run_window("R2", 0, 0, 1);
    run_window("R3", 1, 0, 0);
    run_window("R3", 5, 0, 0);
    run_window("R4", 0, 1, 0);
    run_window("R7", 2, 0, 0);
    run_window("R7", 2, 0, 0);
    // hunt between neighbours to build a lock run
    for (int i = 0; i < 20; i++) run_window("R8", (i % 2 == 0) ? 1 : 2, 0, 0);
    run_window("R8", 0, 0, 0);
    check_int("R8", int'(locked), 1);
    for (int i = 0; i < 4; i++) run_window("R9", 0, 0, 0);
    check_int("R9", int'(locked), 0);
    do_reset(3);
    for (int i = 0; i < 5; i++) run_window("R5", 0, 0, 0);
    check_int("R5", int'(period_word), LO);
    do_reset(3998);
    for (int i = 0; i < 6; i++) run_window("R5", 3, 0, 0);
    check_int("R5", int'(period_word), HI);
    do_reset(500);
    for (int i = 0; i < 80; i++)
      run_window("R4", int'($urandom_range(0, 4)), ($urandom_range(0, 7) == 0), 0);
    run_window("R4", 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule